// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

This unit shifts, rotates or complements a byte, word or long operand by one or two places and produces the four condition flags: negative, zero, overflow and carry. An execution stage uses it. The caller supplies the operand, a size code, an operation code, a single count-select bit and the current carry flag. The result and the flags come out of registers one clock later.

The left and right shifts come in arithmetic and logical forms. The rotates come in plain and through-carry forms. Each operation defines carry and overflow its own way. With the count-select bit set, every shift or rotate is applied twice in sequence, and the carry produced by the first step feeds the second step. Result bits above the selected size are always zero.

Top module: `shrot_unit`

## Requirements
- R1: Reset is synchronous and active high. The clock edge that samples `rst` high sets the result and all four flags to zero.
- R2: Each output reflects the inputs sampled at the previous rising edge. Size code 0 selects byte (8 bits), code 1 selects word (16 bits), and codes 2 and 3 select long (32 bits). Result bits at and above the selected width are zero.
- R3: `twice_i` = 0 moves the operand by one place and `twice_i` = 1 moves it by two places. For count 2, each op applies its single step twice in sequence; the rotate-through-carry ops (R8) feed the first step's carry into the second step.
- R4: Arithmetic left shift (op 0) fills the vacated positions with zeros, and C takes the last bit shifted out of the MSB. For one place, V is set when the MSB and MSB-1 of the operand differ. For two places, V is set when the top three bits of the operand are not all equal.
- R5: Logical left shift (op 1) zero-fills, and C takes the last bit shifted out of the MSB. Logical right shift (op 2) zero-fills at the MSB, and C takes the last bit shifted out of the LSB. Both clear V.
- R6: Arithmetic right shift (op 3) copies the sign bit into the vacated positions, takes the last bit out of the LSB into C, and clears V.
- R7: Plain rotate left (op 4) moves the MSB into both the LSB and C. Plain rotate right (op 5) moves the LSB into both the MSB and C. Both clear V.
- R8: Rotate left through carry (op 6) puts the incoming C into the LSB and the old MSB into C. Rotate right through carry (op 7) puts the incoming C into the MSB and the old LSB into C. Both clear V.
- R9: Complement (op 8, and any code from 9 to 15) inverts the sized operand, clears V, passes `carry_i` through to C and ignores `twice_i`.
- R10: For every operation, N is the MSB of the sized result and Z is set exactly when the sized result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_i | input | LONG_W | Operand; only the sized low bits are used |
| size_i | input | 2 | 0 byte, 1 word, 2 or 3 long |
| op_i | input | 4 | Operation code (0 to 8; 9 to 15 behave as 8) |
| twice_i | input | 1 | Count select: 0 one place, 1 two places |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | LONG_W | Registered result, zero above the size |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |

## Verification
The assertions assume that all inputs carry known values at each rising edge, and they compare each output with the inputs of the previous cycle. An edge with reset high must also precede any checking, because the compare reaches one cycle back. The bench holds reset over several edges and then drives a fresh known input set on each falling clock edge. Its operation codes cover 0 to 8, plus one out-of-range code, so every previous-cycle relation in the checker has defined inputs.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [3:0] {
    OP_SHAL = 4'd0,
    OP_SHLL = 4'd1,
    OP_SHLR = 4'd2,
    OP_SHAR = 4'd3,
    OP_ROTL = 4'd4,
    OP_ROTR = 4'd5,
    OP_RTCL = 4'd6,
    OP_RTCR = 4'd7,
    OP_INV  = 4'd8
  } shrot_op_t;

  localparam int NUM_SIZES = 3;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  shrot_op_t    op_i,
  input  logic         twice_i,
  input  logic         cin_i,
  output logic [W-1:0] r_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int SW = W + 2;

  // one step: returns {v, c, r}
  function automatic logic [SW-1:0] step(shrot_op_t o, logic [W-1:0] x, logic ci);
    logic [W-1:0] r;
    logic c;
    logic v;
    v = 1'b0;
    case (o)
      OP_SHAL: begin r = {x[W-2:0], 1'b0}; c = x[W-1]; v = x[W-1] ^ x[W-2]; end
      OP_SHLL: begin r = {x[W-2:0], 1'b0}; c = x[W-1]; end
      OP_SHLR: begin r = {1'b0, x[W-1:1]}; c = x[0]; end
      OP_SHAR: begin r = {x[W-1], x[W-1:1]}; c = x[0]; end
      OP_ROTL: begin r = {x[W-2:0], x[W-1]}; c = x[W-1]; end
      OP_ROTR: begin r = {x[0], x[W-1:1]}; c = x[0]; end
      OP_RTCL: begin r = {x[W-2:0], ci}; c = x[W-1]; end
      OP_RTCR: begin r = {ci, x[W-1:1]}; c = x[0]; end
      default: begin r = ~x; c = ci; end
    endcase
    return {v, c, r};
  endfunction

  logic [SW-1:0] s1;
  logic [SW-1:0] s2;
  logic          again;

  assign again = twice_i && (op_i != OP_INV) && (op_i <= OP_RTCR);

  always_comb begin
    s1 = step(op_i, a_i, cin_i);
    s2 = step(op_i, s1[W-1:0], s1[W]);
    if (again) begin
      r_o = s2[W-1:0];
      c_o = s2[W];
      v_o = s1[W+1] | s2[W+1];
    end else begin
      r_o = s1[W-1:0];
      c_o = s1[W];
      v_o = s1[W+1];
    end
  end
endmodule

// File: rtl/shrot_pick.sv
module shrot_pick
  import shrot_pkg::*;
#(
  parameter int LONG_W = 32
) (
  input  logic [1:0]                     size_i,
  input  logic [NUM_SIZES-1:0][LONG_W-1:0] r_i,
  input  logic [NUM_SIZES-1:0]           c_i,
  input  logic [NUM_SIZES-1:0]           v_i,
  output logic [LONG_W-1:0]              r_o,
  output logic                           n_o,
  output logic                           z_o,
  output logic                           v_o,
  output logic                           c_o
);
  localparam int BYTE_W = LONG_W / 4;
  localparam int WORD_W = LONG_W / 2;

  logic [1:0] idx;

  always_comb begin
    case (size_i)
      SZ_BYTE: idx = 2'd0;
      SZ_WORD: idx = 2'd1;
      default: idx = 2'd2;
    endcase
    r_o = r_i[idx];
    c_o = c_i[idx];
    v_o = v_i[idx];
    z_o = (r_o == '0);
    case (idx)
      2'd0:    n_o = r_o[BYTE_W-1];
      2'd1:    n_o = r_o[WORD_W-1];
      default: n_o = r_o[LONG_W-1];
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int LONG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LONG_W-1:0] opnd_i,
  input  logic [1:0]        size_i,
  input  logic [3:0]        op_i,
  input  logic              twice_i,
  input  logic              carry_i,
  output logic [LONG_W-1:0] res_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int BYTE_W = LONG_W / 4;

  shrot_op_t                        op;
  logic [NUM_SIZES-1:0][LONG_W-1:0] lane_r;
  logic [NUM_SIZES-1:0]             lane_c;
  logic [NUM_SIZES-1:0]             lane_v;
  logic [LONG_W-1:0]                nx_r;
  logic                             nx_n, nx_z, nx_v, nx_c;

  assign op = (op_i > 4'd8) ? OP_INV : shrot_op_t'(op_i);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = BYTE_W << g;
    logic [LW-1:0] r;
    shrot_lane #(.W(LW)) u_lane (
      .a_i    (opnd_i[LW-1:0]),
      .op_i   (op),
      .twice_i(twice_i),
      .cin_i  (carry_i),
      .r_o    (r),
      .c_o    (lane_c[g]),
      .v_o    (lane_v[g])
    );
    if (LW < LONG_W) begin : g_ext
      assign lane_r[g] = {{(LONG_W-LW){1'b0}}, r};
    end else begin : g_full
      assign lane_r[g] = r;
    end
  end

  shrot_pick #(.LONG_W(LONG_W)) u_pick (
    .size_i(size_i),
    .r_i   (lane_r),
    .c_i   (lane_c),
    .v_i   (lane_v),
    .r_o   (nx_r),
    .n_o   (nx_n),
    .z_o   (nx_z),
    .v_o   (nx_v),
    .c_o   (nx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      n_o   <= 1'b0;
      z_o   <= 1'b0;
      v_o   <= 1'b0;
      c_o   <= 1'b0;
    end else begin
      res_o <= nx_r;
      n_o   <= nx_n;
      z_o   <= nx_z;
      v_o   <= nx_v;
      c_o   <= nx_c;
    end
  end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
  parameter int LONG_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [LONG_W-1:0] opnd_i,
  input logic [1:0]        size_i,
  input logic [3:0]        op_i,
  input logic              twice_i,
  input logic              carry_i,
  input logic [LONG_W-1:0] res_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o
);
  localparam int BYTE_W = LONG_W / 4;
  localparam int WORD_W = LONG_W / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (res_o == '0 && !n_o && !z_o && !v_o && !c_o)); // R1
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (size_i == 2'd0) |=> (res_o[LONG_W-1:BYTE_W] == '0)); // R2
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) (size_i == 2'd1) |=> (res_o[LONG_W-1:WORD_W] == '0)); // R2
  AST_ROTL_ONE_LSB: assert property (@(posedge clk) disable iff (rst) (op_i == 4'd4 && !twice_i) |=> (res_o[0] == c_o)); // R7
  AST_RTCL_ONE_CARRY_IN: assert property (@(posedge clk) disable iff (rst) (op_i == 4'd6 && !twice_i) |=> (res_o[0] == $past(carry_i))); // R8
  AST_NO_V_NONARITH: assert property (@(posedge clk) disable iff (rst) (op_i != 4'd0) |=> !v_o); // R5
  AST_INV_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst) (op_i >= 4'd8) |=> (c_o == $past(carry_i))); // R9
  AST_SHLR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst) (op_i == 4'd2 && size_i[1]) |=> !n_o); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (z_o == (res_o == '0))); // R10
  AST_NEG_LONG: assert property (@(posedge clk) disable iff (rst) size_i[1] |=> (n_o == res_o[LONG_W-1])); // R10
endmodule

bind shrot_unit shrot_chk #(.LONG_W(LONG_W)) u_chk (
  .clk(clk), .rst(rst), .opnd_i(opnd_i), .size_i(size_i), .op_i(op_i),
  .twice_i(twice_i), .carry_i(carry_i), .res_o(res_o), .n_o(n_o),
  .z_o(z_o), .v_o(v_o), .c_o(c_o)
);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd = '0;
  logic [1:0]  size = '0;
  logic [3:0]  op = '0;
  logic        twice = 1'b0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        n, z, v, c;
  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  shrot_unit #(.LONG_W(32)) i_shrot_unit (
    .clk(clk), .rst(rst), .opnd_i(opnd), .size_i(size), .op_i(op),
    .twice_i(twice), .carry_i(cin), .res_o(res), .n_o(n), .z_o(z),
    .v_o(v), .c_o(c)
  );

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd0: return "R4";
      4'd1, 4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected {n,z,v,c,r}
  function automatic logic [35:0] model(logic [3:0] o, logic [1:0] s, logic t,
                                        logic ci, logic [31:0] a);
    int w;
    int k;
    logic [31:0] m, x, r;
    logic cc, vv;
    w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    x = a & m;
    k = t ? 2 : 1;
    vv = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        r = (x << k) & m; cc = x[w-k];
        if (o == 4'd0) vv = t ? !((x[w-1] == x[w-2]) && (x[w-2] == x[w-3])) : (x[w-1] != x[w-2]);
      end
      4'd2: begin r = x >> k; cc = x[k-1]; end
      4'd3: begin r = x >> k; if (x[w-1]) r = r | (m & ~(m >> k)); cc = x[k-1]; end
      4'd4: begin r = ((x << k) | (x >> (w-k))) & m; cc = x[w-k]; end
      4'd5: begin r = ((x >> k) | (x << (w-k))) & m; cc = x[k-1]; end
      4'd6: begin
        if (t) r = ((x << 2) | (32'(ci) << 1) | 32'(x[w-1])) & m;
        else   r = ((x << 1) | 32'(ci)) & m;
        cc = x[w-k];
      end
      4'd7: begin
        if (t) r = (x >> 2) | (32'(ci) << (w-2)) | (32'(x[0]) << (w-1));
        else   r = (x >> 1) | (32'(ci) << (w-1));
        cc = x[k-1];
      end
      default: begin r = ~x & m; cc = ci; end
    endcase
    return {r[w-1], (r == 0), vv, cc, r};
  endfunction

  task automatic drive_check(logic [3:0] o, logic [1:0] s, logic t, logic ci,
                             logic [31:0] a, string tag);
    logic [35:0] e;
    @(negedge clk);
    op = o; size = s; twice = t; cin = ci; opnd = a;
    e = model(o, s, t, ci, a);
    @(posedge clk); #1;
    checks++;
    if ({n, z, v, c, res} !== e) begin
      errors++;
      $display("FAIL %s op=%0d size=%0d twice=%0b: got n%b z%b v%b c%b %h expected n%b z%b v%b c%b %h",
               tag, o, s, t, n, z, v, c, res, e[35], e[34], e[33], e[32], e[31:0]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; op = 4'd8; opnd = 32'h0; size = 2'd2; cin = 1'b1;
    @(posedge clk); #1;
    checks++;
    if ({n, z, v, c, res} !== 36'd0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 0", {n, z, v, c, res});
    end
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_sizes();
    drive_check(4'd1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFC0, "R2");
    drive_check(4'd1, 2'd1, 1'b0, 1'b0, 32'hFFFF_C000, "R2");
    drive_check(4'd1, 2'd3, 1'b1, 1'b0, 32'hC000_0001, "R2");
    drive_check(4'd8, 2'd0, 1'b0, 1'b1, 32'h1234_56FF, "R2 R10");
  endtask

  task automatic t_arith_left();
    drive_check(4'd0, 2'd0, 1'b0, 1'b0, 32'h40, "R4");
    drive_check(4'd0, 2'd0, 1'b0, 1'b0, 32'hC0, "R4");
    drive_check(4'd0, 2'd0, 1'b1, 1'b0, 32'hE0, "R4 R3");
    drive_check(4'd0, 2'd0, 1'b1, 1'b0, 32'hC0, "R4 R3");
    drive_check(4'd0, 2'd1, 1'b1, 1'b0, 32'h2000, "R4 R3");
    drive_check(4'd0, 2'd2, 1'b1, 1'b1, 32'h4000_0000, "R4 R3");
  endtask

  task automatic t_right();
    drive_check(4'd2, 2'd0, 1'b0, 1'b1, 32'h81, "R5");
    drive_check(4'd2, 2'd1, 1'b1, 1'b0, 32'h8002, "R5 R3");
    drive_check(4'd3, 2'd0, 1'b1, 1'b0, 32'h82, "R6 R3");
    drive_check(4'd3, 2'd2, 1'b0, 1'b0, 32'h8000_0001, "R6");
  endtask

  task automatic t_rotate();
    drive_check(4'd4, 2'd0, 1'b0, 1'b0, 32'h80, "R7");
    drive_check(4'd5, 2'd1, 1'b0, 1'b0, 32'h0001, "R7");
    drive_check(4'd4, 2'd2, 1'b1, 1'b0, 32'h4000_0000, "R7 R3");
    drive_check(4'd5, 2'd0, 1'b1, 1'b1, 32'h02, "R7 R3");
  endtask

  task automatic t_through_carry();
    drive_check(4'd6, 2'd0, 1'b0, 1'b1, 32'h00, "R8");
    drive_check(4'd6, 2'd0, 1'b1, 1'b1, 32'h80, "R8 R3");
    drive_check(4'd7, 2'd1, 1'b0, 1'b1, 32'h0001, "R8");
    drive_check(4'd7, 2'd2, 1'b1, 1'b1, 32'h0000_0001, "R8 R3");
    drive_check(4'd7, 2'd0, 1'b1, 1'b0, 32'h02, "R8 R3");
  endtask

  task automatic t_invert();
    drive_check(4'd8, 2'd1, 1'b1, 1'b1, 32'h0000_FFFF, "R9 R10");
    drive_check(4'd8, 2'd2, 1'b0, 1'b0, 32'h7FFF_FFFF, "R9 R10");
    drive_check(4'd12, 2'd0, 1'b1, 1'b1, 32'h5A, "R9");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 400; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      drive_check(4'(seed[3:0] % 9), seed[5:4], seed[6], seed[7],
                  {seed[15:8], seed[31:16], seed[7:0]} ^ {seed[7:0], 24'h0},
                  {tag_of(4'(seed[3:0] % 9)), " R10"});
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        t_reset();
        t_sizes();
        t_arith_left();
        t_right();
        t_rotate();
        t_through_carry();
        t_invert();
        t_sweep();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule